// File: doc/BRIEF.md
# SCL Timing Divider

This block derives the bit timing of a two-wire serial bus from the controller's core clock. It works in two cascaded stages. A prescaler divides the core clock by a power of two, and the exponent comes from a small N field. A second counter then cuts the prescaled rate into slots, each lasting M+1 prescaled pulses. Ten consecutive slots make one SCL period. As a result one bus period lasts 10 × (M+1) × 2^N core cycles. For example, with a 12 MHz prescaled rate, M = 11 gives a 100 kHz bus and M = 2 gives 400 kHz.

The byte engine next to this block does not count cycles itself. It follows four single-cycle enables. The first marks the start of the low half of SCL. The second marks the point where data should be changed, in the middle of the low half. The third marks the rising edge of SCL. The fourth marks the point where data should be sampled, in the middle of the high half. The block also drives a registered SCL level for the pin logic.

The two fields are written through a single configuration port and are held in a shadow register. While the block is running, a new value is applied only at the next period boundary, so a period in progress is never cut short or stretched. Clearing the bus enable, or pulsing soft reset, returns both counters to their idle point with SCL high.

Top module: `scl_clkgen`

## Requirements
- R1: The prescaler emits one pulse every 2^N core cycles, where N is `cfg_data[2:0]` of the last applied write (N = 0 means every cycle).
- R2: With the divider running, consecutive `tick_fall` pulses are exactly 10 × (M+1) × 2^N core cycles apart, where M is `cfg_data[6:3]`.
- R3: A period consists of ten slots. `tick_fall` marks the cycle in which slot 0 starts and `tick_rise` marks slot 5, which is 5 slots later. `scl_level` goes low on the clock edge that ends the `tick_fall` cycle and goes high on the edge that ends the `tick_rise` cycle.
- R4: `tick_drive` occurs 2 slots after `tick_fall`, while SCL is low. `tick_sample` occurs 7 slots after `tick_fall`, while SCL is high.
- R5: If cycle 0 is the first cycle in which `bus_en` is high and `soft_rst` is low, the first `tick_fall` occurs in cycle (M+1) × 2^N − 1.
- R6: While `bus_en` is low, no tick is emitted, `scl_level` is high from the next edge onward, and both counters are held at their idle point.
- R7: A cycle with `soft_rst` high acts as a disabled cycle. After it is released, timing restarts exactly as in R5.
- R8: A write made while the divider is running leaves the current period at its old length. The new fields govern the period that starts at the next `tick_fall`. A write made while the divider is idle is applied before the enable is raised, provided at least one idle cycle follows the write.
- R9: At most one of the four tick outputs is high in any cycle.
- R10: While `rst_n` is low, `scl_level` is high, all ticks are low and both fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restart of both counters |
| bus_en | input | 1 | Counters run while high |
| cfg_wr | input | 1 | Write strobe for the shadow fields |
| cfg_data | input | 7 | Field N in [2:0], field M in [6:3] |
| scl_level | output | 1 | Registered SCL level |
| tick_fall | output | 1 | Start of the SCL low half |
| tick_drive | output | 1 | Mid-low point, time to change data |
| tick_rise | output | 1 | Start of the SCL high half |
| tick_sample | output | 1 | Mid-high point, time to sample data |

## Verification
The first pattern is a full sweep of N from 0 to 3 against every value of M. It measures the first-tick latency and the spacing of all four ticks. Because N and M scale the period differently, this sweep separates faults in the power-of-two stage from faults in the slot counter, and it also covers the degenerate case of one core cycle per slot. Three additional runs with large N exercise the upper shift amounts. Further patterns rewrite the fields in the middle of a period to show that the change is applied only at the boundary, pulse soft reset halfway through the low half to show that timing restarts exactly, and hold the divider idle to show that no ticks are emitted.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int N_W        = 3;
  localparam int M_W        = 4;
  localparam int HALF_SLOTS = 5;
  localparam int SLOTS      = 2 * HALF_SLOTS;
  localparam int PH_W       = $clog2(SLOTS);
  localparam int PRE_W      = (1 << N_W) - 1;
  localparam int NUM_TICKS  = 4;

  // Tick vector positions
  localparam int TK_FALL   = 0;
  localparam int TK_DRIVE  = 1;
  localparam int TK_RISE   = 2;
  localparam int TK_SAMPLE = 3;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } div_cfg_t;

  localparam int CFG_W = $bits(div_cfg_t);

  // Slot a tick's phase enters
  function automatic int entry_slot(input int k);
    case (k)
      TK_FALL:  return 0;
      TK_DRIVE: return HALF_SLOTS / 2;
      TK_RISE:  return HALF_SLOTS;
      default:  return HALF_SLOTS + HALF_SLOTS / 2;
    endcase
  endfunction
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             apply,
  output div_cfg_t         active
);
  div_cfg_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (cfg_wr) shadow <= div_cfg_t'(cfg_data);
      if (apply)  active <= shadow;
    end
  end
endmodule

// File: rtl/scl_div_prescale.sv
module scl_div_prescale
  import scl_div_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [N_W-1:0] n,
  output logic           pulse
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  // low n bits set: 2^n - 1
  assign limit = ~({PRE_W{1'b1}} << n);
  assign pulse = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || pulse) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
  import scl_div_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 pre_pulse,
  input  logic [M_W-1:0]       m,
  output logic [NUM_TICKS-1:0] ticks
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SLOTS - 1);

  logic [M_W-1:0]  m_cnt;
  logic [PH_W-1:0] phase;
  logic            step;

  assign step = pre_pulse && (m_cnt == m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0;
      phase <= LAST;
    end else if (!run) begin
      m_cnt <= '0;
      phase <= LAST;
    end else begin
      if (pre_pulse) m_cnt <= step ? '0 : m_cnt + 1'b1;
      if (step)      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_TICKS; k++) begin : g_tick
    localparam int ENTRY = entry_slot(k);
    localparam int PREV  = (ENTRY == 0) ? SLOTS - 1 : ENTRY - 1;
    assign ticks[k] = step && (phase == PH_W'(PREV));
  end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             bus_en,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             scl_level,
  output logic             tick_fall,
  output logic             tick_drive,
  output logic             tick_rise,
  output logic             tick_sample
);
  div_cfg_t             active;
  logic                 run;
  logic                 apply;
  logic                 pre_pulse;
  logic [NUM_TICKS-1:0] ticks;

  assign run   = bus_en && !soft_rst;
  assign apply = !run || ticks[TK_FALL];

  scl_div_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .apply    (apply),
    .active   (active)
  );

  scl_div_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .n     (active.n),
    .pulse (pre_pulse)
  );

  scl_div_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pre_pulse (pre_pulse),
    .m         (active.m),
    .ticks     (ticks)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 scl_level <= 1'b1;
    else if (!run)              scl_level <= 1'b1;
    else if (ticks[TK_FALL])    scl_level <= 1'b0;
    else if (ticks[TK_RISE])    scl_level <= 1'b1;
  end

  assign tick_fall   = ticks[TK_FALL];
  assign tick_drive  = ticks[TK_DRIVE];
  assign tick_rise   = ticks[TK_RISE];
  assign tick_sample = ticks[TK_SAMPLE];
endmodule

// File: rtl/scl_clkgen_checker.sv
module scl_clkgen_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic bus_en,
  input logic scl_level,
  input logic tick_fall,
  input logic tick_drive,
  input logic tick_rise,
  input logic tick_sample
);
  logic [3:0] tk;
  assign tk = {tick_sample, tick_rise, tick_drive, tick_fall};

  assert_one_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tk));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en || soft_rst) |-> (tk == 4'b0000));

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en || soft_rst) |=> scl_level);

  assert_fall_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |=> !scl_level);

  assert_rise_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> scl_level);

  assert_drive_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_drive |-> !scl_level);

  assert_sample_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample |-> scl_level);
endmodule

bind scl_clkgen scl_clkgen_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .bus_en      (bus_en),
  .scl_level   (scl_level),
  .tick_fall   (tick_fall),
  .tick_drive  (tick_drive),
  .tick_rise   (tick_rise),
  .tick_sample (tick_sample)
);

// File: tb/scl_clkgen_test.sv
module scl_clkgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       bus_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_data = '0;
  logic       scl_level, tick_fall, tick_drive, tick_rise, tick_sample;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int multi  = 0;
  bit done   = 1'b0;

  scl_clkgen uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_en(bus_en),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .scl_level(scl_level),
    .tick_fall(tick_fall), .tick_drive(tick_drive),
    .tick_rise(tick_rise), .tick_sample(tick_sample)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && ($countones({tick_fall, tick_drive, tick_rise, tick_sample}) > 1))
      multi++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tick_sel(input int k);
    case (k)
      0: return tick_fall;
      1: return tick_drive;
      2: return tick_rise;
      default: return tick_sample;
    endcase
  endfunction

  // Returns the cycle index in which tick k is seen, -1 on timeout
  task automatic wait_tick(input int k, input bit from_now, input int limit, output int t);
    t = -1;
    if (from_now) #1;
    else begin @(negedge clk); #1; end
    for (int i = 0; i < limit; i++) begin
      if (tick_sel(k)) begin t = cyc; return; end
      @(negedge clk); #1;
    end
  endtask

  task automatic write_cfg(input int n, input int m);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_data = {m[3:0], n[2:0]};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_config(input int n, input int m);
    int p, t0, tf, td, tr, ts, tf2;
    p = (m + 1) << n;
    @(negedge clk); bus_en = 1'b0;
    write_cfg(n, m);
    @(negedge clk);
    @(negedge clk);
    bus_en = 1'b1;
    t0 = cyc;
    wait_tick(0, 1'b1, p + 4, tf);
    check(tf - t0 == p - 1, "R5 first fall latency", tf - t0, p - 1);
    wait_tick(1, 1'b0, 3 * p + 4, td);
    check(td - tf == 2 * p, "R4 drive offset", td - tf, 2 * p);
    check(scl_level == 1'b0, "R3 low at drive", scl_level, 0);
    wait_tick(2, 1'b0, 4 * p + 4, tr);
    check(tr - tf == 5 * p, "R3 rise offset", tr - tf, 5 * p);
    wait_tick(3, 1'b0, 3 * p + 4, ts);
    check(ts - tf == 7 * p, "R4 sample offset", ts - tf, 7 * p);
    check(scl_level == 1'b1, "R3 high at sample", scl_level, 1);
    wait_tick(0, 1'b0, 4 * p + 4, tf2);
    // R1 prescale and R2 slot divide together set the period
    check(tf2 - tf == 10 * p, "R1 R2 period", tf2 - tf, 10 * p);
    @(negedge clk); bus_en = 1'b0;
  endtask

  initial begin
    int t0, t, tf, tf2, tf3, seen;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(scl_level == 1'b1, "R10 scl high in reset", scl_level, 1);
    check({tick_fall, tick_drive, tick_rise, tick_sample} == 4'b0, "R10 ticks low in reset",
          {tick_fall, tick_drive, tick_rise, tick_sample}, 0);
    rst_n = 1'b1;

    // R10 reset fields are zero: one cycle per slot
    @(negedge clk); bus_en = 1'b1; t0 = cyc;
    wait_tick(0, 1'b1, 8, t);
    check(t - t0 == 0, "R10 zero fields after reset", t - t0, 0);
    wait_tick(0, 1'b0, 20, tf);
    check(tf - t == 10, "R10 zero fields period", tf - t, 10);
    @(negedge clk); bus_en = 1'b0;

    // R6 idle: no ticks, SCL high
    write_cfg(0, 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick_fall || tick_drive || tick_rise || tick_sample || !scl_level) seen++;
    end
    check(seen == 0, "R6 idle quiet", seen, 0);

    // Sweep small N against all M
    for (int n = 0; n < 4; n++)
      for (int m = 0; m < 16; m++)
        run_config(n, m);
    run_config(7, 0);
    run_config(5, 9);
    run_config(7, 15);

    // R7 soft reset in the middle of the low half
    write_cfg(1, 2);
    @(negedge clk);
    @(negedge clk); bus_en = 1'b1;
    wait_tick(1, 1'b1, 40, t);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk);
    check(scl_level == 1'b1, "R7 scl high after soft reset", scl_level, 1);
    check({tick_fall, tick_drive, tick_rise, tick_sample} == 4'b0, "R7 no ticks in soft reset",
          {tick_fall, tick_drive, tick_rise, tick_sample}, 0);
    soft_rst = 1'b0; t0 = cyc;
    wait_tick(0, 1'b1, 20, tf);
    check(tf - t0 == 5, "R7 restart latency", tf - t0, 5);
    wait_tick(0, 1'b0, 80, tf2);
    check(tf2 - tf == 60, "R7 restart period", tf2 - tf, 60);
    @(negedge clk); bus_en = 1'b0;

    // R8 rewrite while running
    write_cfg(0, 3);
    @(negedge clk);
    @(negedge clk); bus_en = 1'b1;
    wait_tick(0, 1'b1, 10, tf);
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; cfg_data = {4'd1, 3'd2};
    @(negedge clk); cfg_wr = 1'b0;
    wait_tick(0, 1'b0, 60, tf2);
    check(tf2 - tf == 40, "R8 current period keeps old length", tf2 - tf, 40);
    wait_tick(0, 1'b0, 100, tf3);
    check(tf3 - tf2 == 80, "R8 next period uses new fields", tf3 - tf2, 80);
    @(negedge clk); bus_en = 1'b0;

    @(negedge clk);
    check(multi == 0, "R9 one tick per cycle", multi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule